// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel. Software sets it up through a small bank of eight 32-bit registers. It then copies data from a source pointer to a destination pointer over a request/grant memory master port. Each beat is one read followed by one write. Each pointer has its own access width and its own auto-increment enable. A byte count is decremented by the size of every beat.

In memory-to-memory mode the channel runs with no pacing. In peripheral mode, one side of the copy is the peripheral FIFO and a request line paces the transfer. Each accepted request moves one burst of bytes. When the count runs out, the channel can load a fresh source pointer, destination pointer and count from shadow registers and carry on.

A prescaled inactivity timer flags a peripheral that has stopped requesting. Count-to-zero, channel-disable and timeout are recorded in sticky flags, and each flag can be routed to one interrupt output.

The register offsets on `cfgAddr` are:

| Offset | Register |
|---|---|
| 0 | control |
| 1 | status |
| 2 | source pointer |
| 3 | destination pointer |
| 4 | count |
| 5 | reload source |
| 6 | reload destination |
| 7 | reload count |

Top module: `dma_chan_engine`

## Requirements
- R1: After reset every register reads zero, `memReq`, `perAck` and `irq` are low, and status busy (bit 3) is low.
- R2: Each pointer's width code is 0 for a byte, 1 for a half-word and 2 for a word. Source width is control bits 6:5 and destination width is control bits 8:7. Each beat moves min(source bytes, destination bytes, remaining count) bytes, shown on `memBytes`, and the count drops by that amount.
- R3: A pointer whose increment enable is set (control bit 3 for source, bit 4 for destination) advances by the bytes of each beat. A pointer whose enable is clear keeps its value.
- R4: When the count reaches zero and the reload count is zero, the channel clears its enable (control bit 0), sets status bit 0 (count-to-zero) and status bit 1 (disabled), and goes idle.
- R5: When the count reaches zero and the reload count is non-zero, the reload pointers and reload count are copied into the working registers and the transfer goes on. The reload count register then reads zero, so a reload happens only once per software write.
- R6: With control bit 1 (memory-to-memory) clear, control bit 2 decides the peripheral side: 1 makes the source the peripheral, 0 makes the destination the peripheral. Accesses to the peripheral side drive `memPeriph` high and `memAddr` zero, and that side's pointer does not move. Each request is acknowledged by a single-cycle `perAck` and moves (control bits 12:9)+1 bytes. No beat starts without a request.
- R7: A read is always followed by its write. `memReq`, `memWe` and `memAddr` hold steady until `memGnt` is seen.
- R8: Clearing the enable while a beat is under way lets that beat finish. The channel then goes idle with status bit 1 set and status bit 0 clear.
- R9: While the channel waits for a request, a timer counts ticks and sets status bit 2 after 4<<sel ticks, where sel is control bits 15:13. Ticks come every 1, 256, 65536 or 16777216 clocks for control bits 17:16 = 0..3. A serviced request restarts the timer.
- R10: With control bit 18 set, the timer does not run until the first request since the channel was enabled.
- R11: Status flags are sticky and are cleared by writing 1 to their bit. `irq` is the OR of each flag ANDed with its enable: control bit 19 for count-to-zero, 20 for disabled, 21 for timeout.
- R12: Enabling the channel with a zero count performs no beat. It sets only the disabled flag and clears the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register offset for read and write |
| cfgWrData | input | 32 | Register write data |
| cfgRdData | output | 32 | Register read data (combinational) |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 for write, 0 for read |
| memPeriph | output | 1 | Access targets the peripheral FIFO |
| memAddr | output | ADDR_W | Byte address |
| memBytes | output | 3 | Bytes in this access (1 to 4) |
| memWdata | output | 32 | Write data, low lanes first |
| memRdata | input | 32 | Read data, valid in the cycle of grant |
| memGnt | input | 1 | Access accepted |
| perReq | input | 1 | Peripheral transfer request |
| perAck | output | 1 | Request accepted pulse |
| irq | output | 1 | Interrupt |

## Verification
The assertions watch the port rules on every cycle:
- the request, direction and address stay stable until grant;
- every granted read is followed by a write;
- the beat size stays between one and four bytes;
- peripheral-side accesses always carry a zero address;
- the request acknowledge is a lone pulse that never overlaps a memory access.

Only the bench's scenarios can show the things that depend on counted bytes and on register contents. These are the end pointers and the moved data for each width and increment combination, the one-shot reload, the flag and interrupt masking, a stop in the middle of a beat, and the timeout period under the prescaler and the request-wait hold-off.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int BURST_W = 4;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_STAT = 3'd1;
  localparam logic [2:0] REG_SRC  = 3'd2;
  localparam logic [2:0] REG_DST  = 3'd3;
  localparam logic [2:0] REG_CNT  = 3'd4;
  localparam logic [2:0] REG_SRCR = 3'd5;
  localparam logic [2:0] REG_DSTR = 3'd6;
  localparam logic [2:0] REG_CNTR = 3'd7;

  typedef struct packed {
    logic               toIe;
    logic               disIe;
    logic               ctzIe;
    logic               reqWait;
    logic [1:0]         psSel;
    logic [2:0]         toSel;
    logic [BURST_W-1:0] burstM1;
    logic [1:0]         dstW;
    logic [1:0]         srcW;
    logic               dstInc;
    logic               srcInc;
    logic               periphSrc;
    logic               m2m;
    logic               en;
  } chanCfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic reqAck;
    logic capRd;
    logic beatDone;
    logic finish;
  } ctrlStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_READ, ST_WRITE} chanState_t;

  function automatic logic [2:0] widthBytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic chanCfg_t decodeCtrl(input logic [31:0] w);
    return chanCfg_t'(w[$bits(chanCfg_t)-1:0]);
  endfunction

  function automatic logic [31:0] encodeCtrl(input chanCfg_t c);
    return 32'(c);
  endfunction

endpackage

// File: rtl/dma_chan_timer.sv
module dma_chan_timer #(
  parameter int PS_STEP   = 8,
  parameter int PS_STAGES = 3,
  parameter int TO_SEL_W  = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 run,
  input  logic                 restart,
  input  logic [TO_SEL_W-1:0]  toSel,
  input  logic [1:0]           psSel,
  output logic                 expire
);
  localparam int PS_W = PS_STEP * PS_STAGES;
  localparam int TO_W = 2 + (1 << TO_SEL_W);

  logic [PS_W-1:0]    psCnt;
  logic [TO_W-1:0]    toCnt;
  logic [PS_STAGES:0] tapHit;
  logic               tick;
  logic               toHit;
  logic [TO_W-1:0]    toLimitM1;

  assign tapHit[0] = 1'b1;
  for (genvar k = 1; k <= PS_STAGES; k++) begin : g_tap
    assign tapHit[k] = &psCnt[k*PS_STEP-1:0];
  end

  assign tick      = tapHit[psSel];
  assign toLimitM1 = (TO_W'(4) << toSel) - TO_W'(1);
  assign toHit     = tick && (toCnt == toLimitM1);
  assign expire    = run && !restart && toHit;

  always_ff @(posedge clk) begin
    if (!rstN || !run || restart) begin
      psCnt <= '0;
      toCnt <= '0;
    end else begin
      psCnt <= tick ? '0 : psCnt + PS_W'(1);
      if (toHit)     toCnt <= '0;
      else if (tick) toCnt <= toCnt + TO_W'(1);
    end
  end
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        en,
  input  logic        m2m,
  input  logic        reqWait,
  input  logic        cntZero,
  input  logic        burstEmpty,
  input  logic        perReq,
  input  logic        memGnt,
  output logic        memReq,
  output logic        memWe,
  output logic        perAck,
  output logic        busy,
  output logic        timerRun,
  output ctrlStrobe_t stb
);
  chanState_t state, nxtState;
  logic       reqSeen;

  always_comb begin
    nxtState = state;
    stb      = '0;
    memReq   = 1'b0;
    memWe    = 1'b0;
    perAck   = 1'b0;
    case (state)
      ST_IDLE: if (en) nxtState = ST_WAIT;
      ST_WAIT: begin
        if (!en || cntZero) begin
          stb.finish = 1'b1;
          nxtState   = ST_IDLE;
        end else if (m2m || !burstEmpty) begin
          nxtState = ST_READ;
        end else if (perReq) begin
          stb.reqAck = 1'b1;
          perAck     = 1'b1;
          nxtState   = ST_READ;
        end
      end
      ST_READ: begin
        memReq = 1'b1;
        if (memGnt) begin
          stb.capRd = 1'b1;
          nxtState  = ST_WRITE;
        end
      end
      default: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memGnt) begin
          stb.beatDone = 1'b1;
          nxtState     = ST_WAIT;
        end
      end
    endcase
  end

  assign busy     = (state != ST_IDLE) || en;
  assign timerRun = (state == ST_WAIT) && en && !m2m && !cntZero && burstEmpty
                    && (!reqWait || reqSeen);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      reqSeen <= 1'b0;
    end else begin
      state <= nxtState;
      if (state == ST_IDLE) reqSeen <= 1'b0;
      else if (stb.reqAck)  reqSeen <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_chan_dpath.sv
module dma_chan_dpath
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [2:0]        cfgAddr,
  input  logic [31:0]       cfgWrData,
  output logic [31:0]       cfgRdData,
  input  ctrlStrobe_t       stb,
  input  logic              timeoutHit,
  input  logic              busy,
  input  logic [31:0]       memRdata,
  output chanCfg_t          cfg,
  output logic              cntZero,
  output logic              burstEmpty,
  output logic [2:0]        beatBytes,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic              rdPeriph,
  output logic              wrPeriph,
  output logic [31:0]       wrData,
  output logic              irq
);
  localparam int BL_W = BURST_W + 1;

  logic [ADDR_W-1:0] srcPtr, dstPtr, srcRld, dstRld;
  logic [CNT_W-1:0]  cnt, cntRld, nextCnt;
  logic [BL_W-1:0]   burstLeft;
  logic              flagCtz, flagDis, flagTo;
  logic [31:0]       dataReg;
  logic [2:0]        lim, srcB, dstB;
  logic              periphMode, wrReg, hitZero;

  assign periphMode = !cfg.m2m;
  assign rdPeriph   = periphMode && cfg.periphSrc;
  assign wrPeriph   = periphMode && !cfg.periphSrc;
  assign rdAddr     = rdPeriph ? '0 : srcPtr;
  assign wrAddr     = wrPeriph ? '0 : dstPtr;
  assign wrData     = dataReg;
  assign cntZero    = (cnt == '0);
  assign burstEmpty = (burstLeft == '0);
  assign wrReg      = cfgWrEn;

  always_comb begin
    srcB = widthBytes(cfg.srcW);
    dstB = widthBytes(cfg.dstW);
    lim  = (srcB < dstB) ? srcB : dstB;
    if (cnt < CNT_W'(lim)) lim = cnt[2:0];
    if (periphMode && (burstLeft < BL_W'(lim))) lim = burstLeft[2:0];
  end
  assign beatBytes = lim;
  assign nextCnt   = cnt - CNT_W'(beatBytes);
  assign hitZero   = stb.beatDone && (nextCnt == '0);

  assign irq = (flagCtz && cfg.ctzIe) || (flagDis && cfg.disIe) || (flagTo && cfg.toIe);

  always_comb begin
    case (cfgAddr)
      REG_CTRL: cfgRdData = encodeCtrl(cfg);
      REG_STAT: cfgRdData = {28'b0, busy, flagTo, flagDis, flagCtz};
      REG_SRC:  cfgRdData = 32'(srcPtr);
      REG_DST:  cfgRdData = 32'(dstPtr);
      REG_CNT:  cfgRdData = 32'(cnt);
      REG_SRCR: cfgRdData = 32'(srcRld);
      REG_DSTR: cfgRdData = 32'(dstRld);
      default:  cfgRdData = 32'(cntRld);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg       <= '0;
      srcPtr    <= '0;
      dstPtr    <= '0;
      srcRld    <= '0;
      dstRld    <= '0;
      cnt       <= '0;
      cntRld    <= '0;
      burstLeft <= '0;
      flagCtz   <= 1'b0;
      flagDis   <= 1'b0;
      flagTo    <= 1'b0;
      dataReg   <= '0;
    end else begin
      if (stb.capRd) dataReg <= memRdata;

      // Working registers: hardware progress first, software write overrides
      if (stb.beatDone) begin
        if (hitZero && (cntRld != '0)) begin
          srcPtr <= srcRld;
          dstPtr <= dstRld;
          cnt    <= cntRld;
          cntRld <= '0;
        end else begin
          cnt <= nextCnt;
          if (cfg.srcInc && !rdPeriph) srcPtr <= srcPtr + ADDR_W'(beatBytes);
          if (cfg.dstInc && !wrPeriph) dstPtr <= dstPtr + ADDR_W'(beatBytes);
        end
      end

      if (wrReg) begin
        case (cfgAddr)
          REG_SRC:  srcPtr <= ADDR_W'(cfgWrData);
          REG_DST:  dstPtr <= ADDR_W'(cfgWrData);
          REG_CNT:  cnt    <= CNT_W'(cfgWrData);
          REG_SRCR: srcRld <= ADDR_W'(cfgWrData);
          REG_DSTR: dstRld <= ADDR_W'(cfgWrData);
          REG_CNTR: cntRld <= CNT_W'(cfgWrData);
          default: ;
        endcase
      end

      if (wrReg && cfgAddr == REG_CTRL) cfg    <= decodeCtrl(cfgWrData);
      else if (stb.finish)               cfg.en <= 1'b0;

      if (stb.finish)                   burstLeft <= '0;
      else if (stb.reqAck)              burstLeft <= BL_W'(cfg.burstM1) + BL_W'(1);
      else if (stb.beatDone && periphMode) burstLeft <= burstLeft - BL_W'(beatBytes);

      if (wrReg && cfgAddr == REG_STAT) begin
        if (cfgWrData[0]) flagCtz <= 1'b0;
        if (cfgWrData[1]) flagDis <= 1'b0;
        if (cfgWrData[2]) flagTo  <= 1'b0;
      end
      if (hitZero)    flagCtz <= 1'b1;
      if (stb.finish) flagDis <= 1'b1;
      if (timeoutHit) flagTo  <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [2:0]        cfgAddr,
  input  logic [31:0]       cfgWrData,
  output logic [31:0]       cfgRdData,
  output logic              memReq,
  output logic              memWe,
  output logic              memPeriph,
  output logic [ADDR_W-1:0] memAddr,
  output logic [2:0]        memBytes,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memGnt,
  input  logic              perReq,
  output logic              perAck,
  output logic              irq
);
  chanCfg_t          cfg;
  ctrlStrobe_t       stb;
  logic              cntZero, burstEmpty, busy, timerRun, timeoutHit;
  logic              rdPeriph, wrPeriph;
  logic [ADDR_W-1:0] rdAddr, wrAddr;

  dma_chan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .en(cfg.en), .m2m(cfg.m2m), .reqWait(cfg.reqWait),
    .cntZero(cntZero), .burstEmpty(burstEmpty), .perReq(perReq), .memGnt(memGnt),
    .memReq(memReq), .memWe(memWe), .perAck(perAck), .busy(busy),
    .timerRun(timerRun), .stb(stb)
  );

  dma_chan_dpath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .stb(stb),
    .timeoutHit(timeoutHit), .busy(busy), .memRdata(memRdata), .cfg(cfg),
    .cntZero(cntZero), .burstEmpty(burstEmpty), .beatBytes(memBytes),
    .rdAddr(rdAddr), .wrAddr(wrAddr), .rdPeriph(rdPeriph), .wrPeriph(wrPeriph),
    .wrData(memWdata), .irq(irq)
  );

  dma_chan_timer u_timer (
    .clk(clk), .rstN(rstN), .run(timerRun), .restart(stb.reqAck),
    .toSel(cfg.toSel), .psSel(cfg.psSel), .expire(timeoutHit)
  );

  assign memAddr   = memWe ? wrAddr : rdAddr;
  assign memPeriph = memWe ? wrPeriph : rdPeriph;
endmodule

// File: rtl/dma_chan_checker.sv
module dma_chan_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memWe,
  input logic              memPeriph,
  input logic [ADDR_W-1:0] memAddr,
  input logic [2:0]        memBytes,
  input logic              memGnt,
  input logic              perAck
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> memReq && $stable(memWe) && $stable(memAddr)); // R7
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memWe && memGnt |=> memReq && memWe); // R7
  AST_BEAT_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memBytes >= 3'd1) && (memBytes <= 3'd4)); // R2
  AST_PERIPH_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memPeriph |-> memAddr == '0); // R6
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    perAck |=> !perAck); // R6
  AST_ACK_NO_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    perAck |-> !memReq); // R6
endmodule

bind dma_chan_engine dma_chan_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe), .memPeriph(memPeriph),
  .memAddr(memAddr), .memBytes(memBytes), .memGnt(memGnt), .perAck(perAck)
);

// File: tb/sim_dma_chan_engine.sv
module sim_dma_chan_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  // columns: srcW, dstW, srcInc, dstInc, count, beats, srcEnd, dstEnd, checkData
  localparam int VEC [0:NVEC-1][0:8] = '{
    '{2, 2, 1, 1, 8, 2, 'h18, 'h88, 1},
    '{0, 2, 1, 1, 5, 5, 'h15, 'h85, 1},
    '{2, 1, 1, 1, 7, 4, 'h17, 'h87, 1},
    '{1, 2, 0, 1, 6, 3, 'h10, 'h86, 0},
    '{2, 2, 1, 0, 3, 1, 'h13, 'h80, 0}
  };

  logic        clk = 1'b0, rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0, cfgRdData;
  logic        memReq, memWe, memPeriph, memGnt = 1'b1, perReq = 1'b0, perAck, irq;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [2:0]  memBytes;
  logic [7:0]  mem [0:255];
  int          wrBeats = 0, ackCnt = 0;
  int          nChecks = 0, nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_engine u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .memReq(memReq), .memWe(memWe),
    .memPeriph(memPeriph), .memAddr(memAddr), .memBytes(memBytes),
    .memWdata(memWdata), .memRdata(memRdata), .memGnt(memGnt), .perReq(perReq),
    .perAck(perAck), .irq(irq)
  );

  assign memRdata = memPeriph ? 32'h44332211 :
    {mem[memAddr[7:0]+8'd3], mem[memAddr[7:0]+8'd2], mem[memAddr[7:0]+8'd1], mem[memAddr[7:0]]};

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
    end else begin
      if (memReq && memGnt && memWe) begin
        wrBeats <= wrBeats + 1;
        if (!memPeriph)
          for (int i = 0; i < 4; i++)
            if (i < int'(memBytes)) mem[memAddr[7:0] + 8'(i)] <= memWdata[8*i +: 8];
      end
      if (perAck) ackCnt <= ackCnt + 1;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk); cfgWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); cfgAddr = a; #1; d = cfgRdData;
  endtask

  function automatic logic [31:0] mkCtrl(input logic en, m2m, psrc, si, di,
      input int sw, dw, burstM1, toSel, ps, input logic rw, ctzIe, disIe, toIe);
    logic [31:0] c = '0;
    c[0] = en; c[1] = m2m; c[2] = psrc; c[3] = si; c[4] = di;
    c[6:5] = 2'(sw); c[8:7] = 2'(dw); c[12:9] = 4'(burstM1);
    c[15:13] = 3'(toSel); c[17:16] = 2'(ps);
    c[18] = rw; c[19] = ctzIe; c[20] = disIe; c[21] = toIe;
    return c;
  endfunction

  task automatic waitIdle();
    logic [31:0] s;
    for (int n = 0; n < 3000; n++) begin
      rd(3'd1, s);
      if (!s[3]) break;
    end
  endtask

  task automatic setup(input int src, dst, cnt);
    wr(3'd1, 32'h7);
    wr(3'd2, 32'(src)); wr(3'd3, 32'(dst)); wr(3'd4, 32'(cnt));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int b0, a0, bad;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    for (int r = 0; r < 8; r++) begin
      rd(3'(r), v);
      chk("R1", "register after reset", v, 32'h0);
    end
    chk("R1", "memReq/perAck/irq", {29'b0, memReq, perAck, irq}, 32'h0);

    // R2 R3 R4 table of memory-to-memory runs
    for (int k = 0; k < NVEC; k++) begin
      setup('h10, 'h80, VEC[k][4]);
      b0 = wrBeats;
      wr(3'd0, mkCtrl(1, 1, 0, VEC[k][2][0], VEC[k][3][0], VEC[k][0], VEC[k][1], 0, 7, 0, 0, 0, 0, 0));
      waitIdle();
      chk("R2", "beat count", 32'(wrBeats - b0), 32'(VEC[k][5]));
      rd(3'd2, v); chk("R3", "source end", v, 32'(VEC[k][6]));
      rd(3'd3, v); chk("R3", "destination end", v, 32'(VEC[k][7]));
      rd(3'd4, v); chk("R2", "count end", v, 32'h0);
      rd(3'd1, v); chk("R4", "status flags", v, 32'h3);
      rd(3'd0, v); chk("R4", "enable cleared", {31'b0, v[0]}, 32'h0);
      if (VEC[k][8] != 0) begin
        bad = 0;
        for (int i = 0; i < VEC[k][4]; i++) if (mem['h80 + i] !== mem['h10 + i]) bad++;
        chk("R2", "copied data mismatches", 32'(bad), 32'h0);
      end
    end

    // R5 one-shot reload
    setup('h10, 'h80, 4);
    wr(3'd5, 32'h40); wr(3'd6, 32'hA0); wr(3'd7, 32'h4);
    b0 = wrBeats;
    wr(3'd0, mkCtrl(1, 1, 0, 1, 1, 2, 2, 0, 7, 0, 0, 0, 0, 0));
    waitIdle();
    chk("R5", "beats with reload", 32'(wrBeats - b0), 32'h2);
    rd(3'd2, v); chk("R5", "source after reload", v, 32'h44);
    rd(3'd3, v); chk("R5", "destination after reload", v, 32'hA4);
    rd(3'd7, v); chk("R5", "reload count consumed", v, 32'h0);
    bad = 0;
    for (int i = 0; i < 4; i++) if (mem['hA0 + i] !== mem['h40 + i]) bad++;
    chk("R5", "reloaded data mismatches", 32'(bad), 32'h0);

    // R6 peripheral source, 4-byte burst per request, byte-wide destination
    setup('h10, 'h80, 8);
    b0 = wrBeats; a0 = ackCnt;
    wr(3'd0, mkCtrl(1, 0, 1, 1, 1, 2, 0, 3, 7, 0, 0, 0, 0, 0));
    repeat (10) @(negedge clk);
    chk("R6", "no beat without request", 32'(wrBeats - b0), 32'h0);
    perReq = 1'b1; @(negedge clk); perReq = 1'b0;
    repeat (30) @(negedge clk);
    chk("R6", "acks after one request", 32'(ackCnt - a0), 32'h1);
    chk("R6", "beats per burst", 32'(wrBeats - b0), 32'h4);
    rd(3'd4, v); chk("R6", "count after burst", v, 32'h4);
    rd(3'd2, v); chk("R6", "peripheral pointer held", v, 32'h10);
    perReq = 1'b1; @(negedge clk); perReq = 1'b0;
    waitIdle();
    rd(3'd1, v); chk("R6", "status after second burst", v, 32'h3);
    rd(3'd3, v); chk("R3", "memory side pointer", v, 32'h88);
    bad = 0;
    for (int i = 0; i < 8; i++) if (mem['h80 + i] !== 8'h11) bad++;
    chk("R6", "peripheral data mismatches", 32'(bad), 32'h0);

    // R8 stop while a beat is outstanding
    setup('h10, 'h80, 8);
    memGnt = 1'b0;
    b0 = wrBeats;
    wr(3'd0, mkCtrl(1, 1, 0, 1, 1, 2, 2, 0, 7, 0, 0, 0, 0, 0));
    while (!memReq) @(negedge clk);
    wr(3'd0, mkCtrl(0, 1, 0, 1, 1, 2, 2, 0, 7, 0, 0, 0, 0, 0));
    memGnt = 1'b1;
    waitIdle();
    chk("R8", "beats after stop", 32'(wrBeats - b0), 32'h1);
    rd(3'd4, v); chk("R8", "count after stop", v, 32'h4);
    rd(3'd1, v); chk("R8", "status after stop", v, 32'h2);

    // R12 zero count
    setup('h10, 'h80, 0);
    b0 = wrBeats;
    wr(3'd0, mkCtrl(1, 1, 0, 1, 1, 2, 2, 0, 7, 0, 0, 0, 0, 0));
    waitIdle();
    chk("R12", "beats with zero count", 32'(wrBeats - b0), 32'h0);
    rd(3'd1, v); chk("R12", "status with zero count", v, 32'h2);

    // R9 timeout, no prescale, 4 ticks
    setup('h10, 'h80, 8);
    wr(3'd0, mkCtrl(1, 0, 1, 1, 1, 2, 0, 0, 0, 0, 0, 0, 0, 1));
    repeat (2) @(negedge clk);
    rd(3'd1, v); chk("R9", "timeout not yet", {31'b0, v[2]}, 32'h0);
    repeat (8) @(negedge clk);
    rd(3'd1, v); chk("R9", "timeout flag", {31'b0, v[2]}, 32'h1);
    chk("R11", "irq from timeout", {31'b0, irq}, 32'h1);
    wr(3'd0, mkCtrl(0, 0, 1, 1, 1, 2, 0, 0, 0, 0, 0, 0, 0, 1));
    waitIdle();
    wr(3'd1, 32'h4);
    rd(3'd1, v); chk("R11", "write-1 clears only timeout", v, 32'h2);
    wr(3'd1, 32'h2);
    rd(3'd1, v); chk("R11", "all flags cleared", v, 32'h0);

    // R10 request-wait hold-off
    setup('h10, 'h80, 8);
    wr(3'd0, mkCtrl(1, 0, 1, 1, 1, 2, 0, 0, 0, 0, 1, 0, 0, 0));
    repeat (40) @(negedge clk);
    rd(3'd1, v); chk("R10", "no timeout before first request", {31'b0, v[2]}, 32'h0);
    wr(3'd0, mkCtrl(0, 0, 1, 1, 1, 2, 0, 0, 0, 0, 1, 0, 0, 0));
    waitIdle();

    // R9 prescale by 256: expiry near 1024 clocks
    setup('h10, 'h80, 8);
    wr(3'd0, mkCtrl(1, 0, 1, 1, 1, 2, 0, 0, 0, 1, 0, 0, 0, 0));
    repeat (990) @(negedge clk);
    rd(3'd1, v); chk("R9", "prescaled timeout early", {31'b0, v[2]}, 32'h0);
    repeat (80) @(negedge clk);
    rd(3'd1, v); chk("R9", "prescaled timeout", {31'b0, v[2]}, 32'h1);
    wr(3'd0, mkCtrl(0, 0, 1, 1, 1, 2, 0, 0, 0, 1, 0, 0, 0, 0));
    waitIdle();

    // R11 interrupt masking of count-to-zero
    setup('h10, 'h80, 4);
    wr(3'd0, mkCtrl(1, 1, 0, 1, 1, 2, 2, 0, 7, 0, 0, 1, 0, 0));
    waitIdle();
    chk("R11", "irq with ctz enabled", {31'b0, irq}, 32'h1);
    wr(3'd0, mkCtrl(0, 1, 0, 1, 1, 2, 2, 0, 7, 0, 0, 0, 0, 0));
    chk("R11", "irq masked", {31'b0, irq}, 32'h0);
    rd(3'd1, v); chk("R11", "flag stays sticky", {31'b0, v[0]}, 32'h1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule